// File: doc/BRIEF.md
# Burst Throughput Measurement Master

This block is an AXI master that times bulk transfers between a local 512-word, 64-bit buffer RAM and external memory. A one-cycle start pulse, qualified by a direction select, launches a run. In the write direction the block reads the buffer and sends it out as write bursts. In the read direction it fetches read bursts and stores the returned beats into the buffer. A run is eight passes of 2 KB each. Every pass is sixteen 16-beat INCR bursts at 128-byte address steps. Addresses continue from one pass to the next, so pass n starts at byte n×2048.

For each pass, a cycle timer counts clocks from the first address-valid cycle of the pass to the handshake of the pass's final data beat, and then holds that value. When a pass ends, the block gives a one-cycle result strobe carrying the pass index and the held count. A write pass ends only after the response to its last burst has been accepted. A one-cycle done pulse follows the eighth result. A side port lets surrounding logic fill and inspect the buffer between runs.

Top module: `axtp_master`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, res_valid, awvalid, wvalid, bready, arvalid and rready are all 0.
- R2: A start pulse while idle makes the block busy. It produces exactly eight result strobes with res_index 0,1,…,7 in that order, then a done pulse in the cycle directly after the strobe with index 7, then returns to idle with no further channel activity.
- R3: Every burst is issued with length field 15 (16 beats), size field 3 (8 bytes), burst field 2'b01 (INCR), and every write beat has all eight strobe bits set.
- R4: Across a run, burst k (counted from 0, over all passes) carries address k×128, so pass n begins at n×2048. An address held while not accepted keeps its value. A run issues exactly 128 bursts.
- R5: Write beat j of a run (counted from 0) carries buffer word j mod 512. WLAST is 1 exactly on every 16th beat. Data and WLAST stay stable while WVALID waits for WREADY.
- R6: In the write direction, a pass's result strobe comes only after the write response of that pass's sixteenth burst has been accepted.
- R7: In the read direction, read beat j of the run is stored into buffer word j mod 512. After a run, buffer word i holds the beat returned for memory word 1536+i.
- R8: res_cycles equals the number of clock cycles from the first cycle of the pass's first address-valid through the handshake cycle of its 256th data beat, both ends counted. The count holds after that beat.
- R9: A start pulse while busy is ignored. The running direction, burst count and result sequence are unchanged.
- R10: While idle, a write on the buffer side port stores the word, and a read returns the addressed word one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run trigger, sampled while idle |
| dir_read | input | 1 | Run direction at start: 0 write to memory, 1 read from memory |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the eighth result |
| res_valid | output | 1 | One-cycle pass result strobe |
| res_index | output | 3 | Pass number of the result, 0 first |
| res_cycles | output | 32 | Measured cycle count of the pass |
| buf_wr_en | input | 1 | Side-port buffer write enable (idle only) |
| buf_addr | input | 9 | Side-port buffer word address |
| buf_wdata | input | 64 | Side-port write data |
| buf_rdata | output | 64 | Side-port read data, one cycle after address |
| awaddr | output | 32 | Write burst address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 64 | Write beat data |
| wstrb | output | 8 | Write byte strobes |
| wlast | output | 1 | Final beat of a write burst |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | 32 | Read burst address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 64 | Read beat data |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
A wrong word counter shows up on the first burst it touches, as a wrong address on the address channel, a misplaced WLAST, or a wrong write beat. Each of these is compared at the handshake where it happens. A broken buffer read-ahead gives stale or changing write data under slave back-pressure, which is visible within one beat. Timer faults appear in the result strobe at the end of the same pass, because the bench counts the same window from the channel handshakes. Read-direction storage faults stay hidden until the buffer is read back after done, so that check runs over the whole buffer.

// File: rtl/axtp_pkg.sv
package axtp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_DATA   = 3'd2,
      ST_RESP   = 3'd3,
      ST_REPORT = 3'd4,
      ST_DONE   = 3'd5
   } seq_state_t;

   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } xfer_dir_t;

   localparam logic [1:0] AXI_BURST_INCR = 2'b01;

   function automatic logic [2:0] beat_size_code(input int bytes);
      return 3'($clog2(bytes));
   endfunction

endpackage

// File: rtl/axtp_buf_ram.sv
module axtp_buf_ram #(
   parameter int DEPTH  = 512,
   parameter int DATA_W = 64
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DATA_W-1:0]        rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/axtp_cycle_timer.sv
module axtp_cycle_timer #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             stop_i,
   output logic [CNT_W-1:0] count_o,
   output logic             active_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             act_q;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (!act_q && go_i) begin
         cnt_q <= CNT_W'(1);
         act_q <= 1'b1;
      end else if (act_q) begin
         cnt_q <= cnt_inc;
         if (stop_i) begin
            act_q <= 1'b0;
         end
      end
   end

   assign count_o  = cnt_q;
   assign active_o = act_q;

   // R8: the count holds between passes
   a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_q && !go_i) |=> $stable(cnt_q));

   // R8: the final beat of a pass only arrives inside a timed window
   a_r8_stop_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |-> act_q);

endmodule

// File: rtl/axtp_seq.sv
module axtp_seq
   import axtp_pkg::*;
#(
   parameter int BURST_LEN = 16,
   parameter int BURSTS    = 16,
   parameter int PASSES    = 8,
   parameter int RUN_W     = 11,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             dir_read_i,
   input  logic             a_ready_i,
   input  logic             w_ready_i,
   input  logic             b_valid_i,
   input  logic             r_valid_i,
   output seq_state_t       state_o,
   output xfer_dir_t        dir_o,
   output logic [RUN_W-1:0] word_o,
   output logic [IDX_W-1:0] pass_o,
   output logic             data_fire_o,
   output logic             beat_last_o,
   output logic             pass_first_o,
   output logic             pass_last_o
);

   localparam int BEAT_W = $clog2(BURST_LEN);
   localparam int PW_W   = $clog2(BURST_LEN * BURSTS);

   seq_state_t       state_q;
   xfer_dir_t        dir_q;
   logic [RUN_W-1:0] word_q;
   logic [IDX_W-1:0] pass_q;
   logic             fire;
   logic             beat_last;
   logic             pass_last;

   always_comb begin
      fire      = (state_q == ST_DATA) &&
                  ((dir_q == DIR_WRITE) ? w_ready_i : r_valid_i);
      beat_last = &word_q[BEAT_W-1:0];
      pass_last = &word_q[PW_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= DIR_WRITE;
         word_q  <= '0;
         pass_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  dir_q   <= xfer_dir_t'(dir_read_i);
                  word_q  <= '0;
                  pass_q  <= '0;
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (a_ready_i) begin
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (fire) begin
                  word_q <= word_q + 1'b1;
                  if (beat_last) begin
                     if (dir_q == DIR_WRITE) begin
                        state_q <= ST_RESP;
                     end else begin
                        state_q <= pass_last ? ST_REPORT : ST_ADDR;
                     end
                  end
               end
            end
            ST_RESP: begin
               if (b_valid_i) begin
                  state_q <= (word_q[PW_W-1:0] == '0) ? ST_REPORT : ST_ADDR;
               end
            end
            ST_REPORT: begin
               if (pass_q == IDX_W'(PASSES - 1)) begin
                  state_q <= ST_DONE;
               end else begin
                  pass_q  <= pass_q + 1'b1;
                  state_q <= ST_ADDR;
               end
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o      = state_q;
   assign dir_o        = dir_q;
   assign word_o       = word_q;
   assign pass_o       = pass_q;
   assign data_fire_o  = fire;
   assign beat_last_o  = beat_last;
   assign pass_first_o = (word_q[PW_W-1:0] == '0);
   assign pass_last_o  = pass_last;

   // R2: the done state is only reached from a result report
   a_r2_done_from_report: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE) |-> ($past(state_q) == ST_REPORT));

   // R4: the address phase always starts on a burst boundary
   a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR) |-> (word_q[BEAT_W-1:0] == '0));

endmodule

// File: rtl/axtp_master.sv
module axtp_master
   import axtp_pkg::*;
#(
   parameter int  ADDR_W    = 32,
   parameter int  DATA_W    = 64,
   parameter int  BUF_DEPTH = 512,
   parameter int  BURST_LEN = 16,
   parameter int  BURSTS    = 16,
   parameter int  PASSES    = 8,
   parameter int  CNT_W     = 32,
   parameter bit  SATURATE  = 1'b1,
   localparam int BUF_AW    = $clog2(BUF_DEPTH),
   localparam int IDX_W     = $clog2(PASSES),
   localparam int STRB_W    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_read,
   output logic              busy,
   output logic              done,
   output logic              res_valid,
   output logic [IDX_W-1:0]  res_index,
   output logic [CNT_W-1:0]  res_cycles,
   input  logic              buf_wr_en,
   input  logic [BUF_AW-1:0] buf_addr,
   input  logic [DATA_W-1:0] buf_wdata,
   output logic [DATA_W-1:0] buf_rdata,
   output logic [ADDR_W-1:0] awaddr,
   output logic [7:0]        awlen,
   output logic [2:0]        awsize,
   output logic [1:0]        awburst,
   output logic              awvalid,
   input  logic              awready,
   output logic [DATA_W-1:0] wdata,
   output logic [STRB_W-1:0] wstrb,
   output logic              wlast,
   output logic              wvalid,
   input  logic              wready,
   input  logic              bvalid,
   output logic              bready,
   output logic [ADDR_W-1:0] araddr,
   output logic [7:0]        arlen,
   output logic [2:0]        arsize,
   output logic [1:0]        arburst,
   output logic              arvalid,
   input  logic              arready,
   input  logic [DATA_W-1:0] rdata,
   input  logic              rvalid,
   output logic              rready
);

   localparam int BYTE_SH    = $clog2(STRB_W);
   localparam int PASS_WORDS = BURST_LEN * BURSTS;
   localparam int RUN_W      = $clog2(PASS_WORDS * PASSES);

   generate
      if (BUF_DEPTH != (1 << BUF_AW)) begin : g_chk_depth
         $error("BUF_DEPTH must be a power of two");
      end
      if (BURST_LEN < 2 || BURST_LEN > 256 || BURST_LEN != (1 << $clog2(BURST_LEN))) begin : g_chk_len
         $error("BURST_LEN must be a power of two in 2..256");
      end
      if (BURSTS != (1 << $clog2(BURSTS))) begin : g_chk_bursts
         $error("BURSTS must be a power of two");
      end
      if (PASSES < 2 || PASSES != (1 << IDX_W)) begin : g_chk_passes
         $error("PASSES must be a power of two of at least 2");
      end
      if (DATA_W < 16 || DATA_W != (1 << $clog2(DATA_W))) begin : g_chk_data
         $error("DATA_W must be a power of two of at least 16");
      end
      if (ADDR_W < RUN_W + BYTE_SH) begin : g_chk_addr
         $error("ADDR_W too narrow for the run span");
      end
   endgenerate

   seq_state_t        state;
   xfer_dir_t         dir;
   logic [RUN_W-1:0]  word;
   logic [IDX_W-1:0]  pass;
   logic              data_fire;
   logic              beat_last;
   logic              pass_first;
   logic              pass_last;
   logic              a_ready;
   logic [BUF_AW-1:0] bidx;
   logic [BUF_AW-1:0] ram_raddr;
   logic [BUF_AW-1:0] ram_waddr;
   logic [DATA_W-1:0] ram_wdata;
   logic              ram_we;
   logic [DATA_W-1:0] ram_q;
   logic [ADDR_W-1:0] burst_addr;
   logic              timer_go;
   logic              timer_stop;
   logic              timer_active;
   logic              w_fire;
   logic              r_fire;

   axtp_seq #(
      .BURST_LEN (BURST_LEN),
      .BURSTS    (BURSTS),
      .PASSES    (PASSES),
      .RUN_W     (RUN_W),
      .IDX_W     (IDX_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .dir_read_i   (dir_read),
      .a_ready_i    (a_ready),
      .w_ready_i    (wready),
      .b_valid_i    (bvalid),
      .r_valid_i    (rvalid),
      .state_o      (state),
      .dir_o        (dir),
      .word_o       (word),
      .pass_o       (pass),
      .data_fire_o  (data_fire),
      .beat_last_o  (beat_last),
      .pass_first_o (pass_first),
      .pass_last_o  (pass_last)
   );

   // buffer index is the run word counter modulo the buffer depth
   generate
      if (RUN_W >= BUF_AW) begin : g_idx_trunc
         assign bidx = word[BUF_AW-1:0];
      end else begin : g_idx_ext
         assign bidx = BUF_AW'(word);
      end
   endgenerate

   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);
   assign res_valid  = (state == ST_REPORT);
   assign res_index  = pass;

   assign a_ready    = (dir == DIR_WRITE) ? awready : arready;
   assign burst_addr = ADDR_W'({word, {BYTE_SH{1'b0}}});

   assign awvalid    = (state == ST_ADDR) && (dir == DIR_WRITE);
   assign arvalid    = (state == ST_ADDR) && (dir == DIR_READ);
   assign awaddr     = burst_addr;
   assign araddr     = burst_addr;
   assign awlen      = 8'(BURST_LEN - 1);
   assign arlen      = 8'(BURST_LEN - 1);
   assign awsize     = beat_size_code(STRB_W);
   assign arsize     = beat_size_code(STRB_W);
   assign awburst    = AXI_BURST_INCR;
   assign arburst    = AXI_BURST_INCR;

   assign wvalid     = (state == ST_DATA) && (dir == DIR_WRITE);
   assign wlast      = wvalid && beat_last;
   assign wstrb      = '1;
   assign wdata      = ram_q;
   assign bready     = (state == ST_RESP);
   assign rready     = (state == ST_DATA) && (dir == DIR_READ);

   assign w_fire     = wvalid && data_fire;
   assign r_fire     = rready && data_fire;

   // read-ahead: on a write handshake the RAM fetches the next word so the
   // following beat is ready without a bubble
   always_comb begin
      if (busy) begin
         ram_raddr = w_fire ? bidx + 1'b1 : bidx;
         ram_we    = r_fire;
         ram_waddr = bidx;
         ram_wdata = rdata;
      end else begin
         ram_raddr = buf_addr;
         ram_we    = buf_wr_en;
         ram_waddr = buf_addr;
         ram_wdata = buf_wdata;
      end
   end

   assign buf_rdata = ram_q;

   axtp_buf_ram #(
      .DEPTH  (BUF_DEPTH),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (ram_raddr),
      .rdata (ram_q)
   );

   assign timer_go   = (awvalid || arvalid) && pass_first;
   assign timer_stop = data_fire && pass_last;

   axtp_cycle_timer #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (timer_go),
      .stop_i   (timer_stop),
      .count_o  (res_cycles),
      .active_o (timer_active)
   );

   // R2: only one channel phase is open at any time
   a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({awvalid, wvalid, bready, arvalid, rready}));

   // R2: done directly follows the last pass result
   a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(res_valid) && ($past(res_index) == IDX_W'(PASSES - 1))));

   // R4: a write address waiting for ready holds
   a_r4_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

   // R4: a read address waiting for ready holds
   a_r4_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid && !arready) |=> (arvalid && $stable(araddr)));

   // R5: a stalled write beat keeps its payload
   a_r5_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));

   // R6: a write result follows an accepted response
   a_r6_result_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (dir == DIR_WRITE)) |-> $past(bvalid && bready));

   // R8: the timer is closed when a result is reported
   a_r8_closed_at_report: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !timer_active);

   // R9: a start while busy does not end the run
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

endmodule

// File: tb/axtp_master_test.sv
`timescale 1ns/1ps
module axtp_master_test;

   localparam int NV = 6;
   // {dir_read, stall modulus}
   localparam logic [3:0] VEC [NV] = '{4'b0_000, 4'b1_000, 4'b0_011,
                                       4'b1_010, 4'b0_101, 4'b1_100};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start, dir_read;
   logic        busy, done, res_valid;
   logic [2:0]  res_index;
   logic [31:0] res_cycles;
   logic        buf_wr_en;
   logic [8:0]  buf_addr;
   logic [63:0] buf_wdata, buf_rdata;
   logic [31:0] awaddr, araddr;
   logic [7:0]  awlen, arlen;
   logic [2:0]  awsize, arsize;
   logic [1:0]  awburst, arburst;
   logic        awvalid, awready, wlast, wvalid, wready, bvalid, bready;
   logic        arvalid, arready, rvalid, rready;
   logic [63:0] wdata, rdata;
   logic [7:0]  wstrb;

   always #2.5 clk = ~clk;

   axtp_master uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_read(dir_read),
      .busy(busy), .done(done), .res_valid(res_valid), .res_index(res_index),
      .res_cycles(res_cycles), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
      .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
      .awvalid(awvalid), .awready(awready), .wdata(wdata), .wstrb(wstrb),
      .wlast(wlast), .wvalid(wvalid), .wready(wready), .bvalid(bvalid),
      .bready(bready), .araddr(araddr), .arlen(arlen), .arsize(arsize),
      .arburst(arburst), .arvalid(arvalid), .arready(arready), .rdata(rdata),
      .rvalid(rvalid), .rready(rready)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- memory-side slave model ----------------
   logic [63:0] smem [2048];
   logic [63:0] bmod [512];
   int cyc = 0;
   int stall_m = 0;
   int w_ptr = 0, w_beat = 0, r_ptr = 0, r_beat = 0;
   logic r_act = 1'b0;
   logic bv_q = 1'b0;

   function automatic bit pat(input int m, input int c);
      return (m == 0) || ((c % m) != 0);
   endfunction

   assign awready = pat(stall_m, cyc);
   assign arready = pat(stall_m, cyc);
   assign wready  = pat(stall_m, cyc + 1);
   assign rvalid  = r_act && pat(stall_m, cyc + 2);
   assign rdata   = smem[(r_ptr + r_beat) % 2048];
   assign bvalid  = bv_q;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (awvalid && awready) begin
         w_ptr  <= int'(awaddr[13:3]);
         w_beat <= 0;
      end
      if (wvalid && wready) begin
         smem[(w_ptr + w_beat) % 2048] = wdata;
         w_beat <= w_beat + 1;
         if (wlast) bv_q <= 1'b1;
      end
      if (bv_q && bready) bv_q <= 1'b0;
      if (arvalid && arready) begin
         r_ptr  <= int'(araddr[13:3]);
         r_beat <= 0;
         r_act  <= 1'b1;
      end
      if (rvalid && rready) begin
         r_beat <= r_beat + 1;
         if (r_beat == 15) r_act <= 1'b0;
      end
   end

   // ---------------- port monitor ----------------
   bit mon_en = 1'b0;
   bit mon_write = 1'b1;
   int a_n, w_n, r_n, b_n, res_n, done_n, aw_tot, ar_tot;
   bit meas_on;
   int meas, last_meas;
   bit prev_res;
   logic [2:0] prev_idx;

   always @(negedge clk) begin
      if (mon_en) begin
         if (!meas_on && (awvalid || arvalid) && (a_n % 16 == 0)) begin
            meas_on = 1'b1;
            meas = 0;
         end
         if (meas_on) meas++;
         if (awvalid && awready) begin
            check(awaddr == 32'(a_n * 128), "R4 awaddr", awaddr, a_n * 128);
            check(awlen == 8'd15 && awsize == 3'd3 && awburst == 2'b01, "R3 aw fields",
                  {awlen, 1'b0, awsize, awburst}, {8'd15, 1'b0, 3'd3, 2'b01});
            a_n++; aw_tot++;
         end
         if (arvalid && arready) begin
            check(araddr == 32'(a_n * 128), "R4 araddr", araddr, a_n * 128);
            check(arlen == 8'd15 && arsize == 3'd3 && arburst == 2'b01, "R3 ar fields",
                  {arlen, 1'b0, arsize, arburst}, {8'd15, 1'b0, 3'd3, 2'b01});
            a_n++; ar_tot++;
         end
         if (wvalid && wready) begin
            check(wdata == bmod[w_n % 512], "R5 wdata", wdata, bmod[w_n % 512]);
            check(wlast == (w_n % 16 == 15), "R5 wlast", wlast, (w_n % 16 == 15));
            check(wstrb == 8'hFF, "R3 wstrb", wstrb, 8'hFF);
            if (w_n % 256 == 255) begin meas_on = 1'b0; last_meas = meas; end
            w_n++;
         end
         if (rvalid && rready) begin
            if (r_n % 256 == 255) begin meas_on = 1'b0; last_meas = meas; end
            r_n++;
         end
         if (bvalid && bready) b_n++;
         if (res_valid) begin
            check(res_index == 3'(res_n), "R2 res_index", res_index, res_n);
            check(res_cycles == 32'(last_meas), "R8 res_cycles", res_cycles, last_meas);
            if (mon_write) check(b_n == (res_n + 1) * 16, "R6 responses before result", b_n, (res_n + 1) * 16);
            res_n++;
         end
         if (done) begin
            check(prev_res && prev_idx == 3'd7, "R2 done timing", {prev_res, prev_idx}, 4'hF);
            done_n++;
         end
         prev_res = res_valid;
         prev_idx = res_index;
      end
   end

   // ---------------- host buffer port tasks ----------------
   task automatic host_write(input int a, input logic [63:0] d);
      @(negedge clk);
      buf_wr_en = 1'b1; buf_addr = 9'(a); buf_wdata = d;
      @(negedge clk);
      buf_wr_en = 1'b0;
   endtask

   task automatic host_read(input int a, output logic [63:0] d);
      @(negedge clk);
      buf_addr = 9'(a);
      @(negedge clk);
      d = buf_rdata;
   endtask

   task automatic idle_check(input string req);
      check(!busy && !done && !res_valid && !awvalid && !wvalid && !bready && !arvalid && !rready,
            req, {busy, done, res_valid, awvalid, wvalid, bready, arvalid, rready}, 0);
   endtask

   task automatic run(input bit rd, input int stall, input int seed, input bit poke);
      int lim;
      int bad;
      logic [63:0] d;
      stall_m = stall;
      if (!rd) begin
         for (int i = 0; i < 512; i++) begin
            bmod[i] = {32'(seed * 1000 + i), 32'hC0DE0000 ^ 32'(i * 7)};
            host_write(i, bmod[i]);
         end
         for (int k = 0; k < 2048; k++) smem[k] = '1;
      end else begin
         for (int k = 0; k < 2048; k++) smem[k] = {32'hFEED0000 ^ 32'(k), 32'(seed * 31 + k * 13)};
      end
      a_n = 0; w_n = 0; r_n = 0; b_n = 0; res_n = 0; done_n = 0;
      aw_tot = 0; ar_tot = 0; meas_on = 1'b0; meas = 0; last_meas = 0; prev_res = 1'b0;
      mon_write = !rd;
      mon_en = 1'b1;
      @(negedge clk);
      start = 1'b1; dir_read = rd;
      @(negedge clk);
      start = 1'b0;
      lim = 0;
      while (done_n == 0 && lim < 30000) begin
         @(negedge clk);
         lim++;
         if (poke && (lim == 60 || lim == 61)) begin
            start = 1'b1; dir_read = !rd;      // R9: start while busy
         end else begin
            start = 1'b0;
         end
      end
      check(lim < 30000, "R2 run completes", lim, 30000);
      repeat (20) @(negedge clk);
      idle_check("R2 idle after done");
      check(res_n == 8, "R2 result count", res_n, 8);
      check(done_n == 1, "R2 done count", done_n, 1);
      check(a_n == 128, "R4 burst count", a_n, 128);
      if (poke) check(rd ? (aw_tot == 0) : (ar_tot == 0), "R9 direction kept", rd ? aw_tot : ar_tot, 0);
      mon_en = 1'b0;
      bad = 0;
      if (!rd) begin
         for (int k = 0; k < 2048; k++) if (smem[k] != bmod[k % 512]) bad++;
         check(bad == 0, "R5 memory contents", bad, 0);
      end else begin
         for (int i = 0; i < 512; i++) begin
            host_read(i, d);
            if (d != smem[1536 + i]) bad++;
         end
         check(bad == 0, "R7 buffer contents", bad, 0);
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin
      logic [63:0] d;
      rst_n = 1'b0; start = 1'b0; dir_read = 1'b0;
      buf_wr_en = 1'b0; buf_addr = '0; buf_wdata = '0;
      repeat (3) @(negedge clk);
      idle_check("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1 after reset");

      // R10: side port write and read back
      host_write(5, 64'h1122_3344_5566_7788);
      host_write(6, 64'h99AA_BBCC_DDEE_FF00);
      host_read(5, d);
      check(d == 64'h1122_3344_5566_7788, "R10 readback 5", d, 64'h1122_3344_5566_7788);
      host_read(6, d);
      check(d == 64'h99AA_BBCC_DDEE_FF00, "R10 readback 6", d, 64'h99AA_BBCC_DDEE_FF00);

      for (int v = 0; v < NV; v++) begin
         run(VEC[v][3], int'(VEC[v][2:0]), v + 1, 1'b0);
      end

      // R9: start pulses during a write run, then during a read run
      run(1'b0, 2, 11, 1'b1);
      run(1'b1, 3, 12, 1'b1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule